// File: doc/BRIEF.md
# Serial Micro-Step Command Register

This block takes micro-step current commands for a pair of stepper-motor windings over a three-wire serial link. The three wires are a data line, a shift clock and a strobe. It also has a setup select and an active-low reset. The three link wires and the setup select are synchronised to the system clock. Edges of the shift clock and the strobe are detected in the system-clock domain.

Each rising edge of the shift clock pushes one bit into a 16-bit shift register, most significant bit first. A rising strobe edge then transfers that word in one of two ways:

- With setup low, the word goes to the command latch of the winding named by bit 15. That latch holds a phase bit, a 4-bit current level, a 2-bit torque select and a 2-bit decay selector.
- With setup high, the word instead overwrites a four-entry mixed-decay timing table.

Every output is a plain registered field, or a field decoded from registers:

- the phase bit, the DAC level and the torque select of each winding;
- the torque scale in percent;
- the decay timing value that the winding's decay selector picks out of the table.

Top module: `ms_cmd_register`

## Requirements
- R1: Each rising edge of `ser_clk` shifts `ser_data` into a 16-bit register, MSB first. At a strobe, the word used is the last 16 bits shifted in, and the first of those 16 bits lands in bit 15.
- R2: A rising edge of `ser_strobe` with `setup` low loads exactly one winding latch. Word bit 15 picks it: 0 loads winding A and 1 loads winding B. The other winding's outputs stay unchanged.
- R3: A command word is laid out as follows: bit 8 is the phase, bits 7:4 the current level, bits 3:2 the torque select and bits 1:0 the decay selector. Bits 14:9 have no effect. The current level appears unchanged on the winding's `*_level` output.
- R4: `*_torque_pct` decodes the latched torque select: 00 gives 100, 01 gives 85, 10 gives 70 and 11 gives 50.
- R5: A rising edge of `ser_strobe` with `setup` high writes the word into the timing table, with entry k taken from bits 4k+3:4k. Both winding latches stay unchanged.
- R6: `*_decay_time` equals the table entry that the winding's latched decay selector picks.
- R7: While `rst_n` is low at a clock edge, both winding latches clear to zero and the shift register clears. The table loads its defaults: entry 0 = 1, entry 1 = 3, entry 2 = 6, entry 3 = 10.
- R8: Shift-clock activity with no strobe edge changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_data | input | 1 | Serial data bit |
| ser_clk | input | 1 | Serial shift clock; a rising edge shifts |
| ser_strobe | input | 1 | Transfer strobe; a rising edge transfers |
| setup | input | 1 | High routes the transfer to the timing table |
| a_phase | output | 1 | Winding A phase bit |
| a_level | output | 4 | Winding A current level (DAC code) |
| a_torque | output | 2 | Winding A torque select |
| a_torque_pct | output | 7 | Winding A torque scale in percent |
| a_decay_sel | output | 2 | Winding A decay selector |
| a_decay_time | output | 4 | Winding A selected decay timing value |
| b_phase | output | 1 | Winding B phase bit |
| b_level | output | 4 | Winding B current level (DAC code) |
| b_torque | output | 2 | Winding B torque select |
| b_torque_pct | output | 7 | Winding B torque scale in percent |
| b_decay_sel | output | 2 | Winding B decay selector |
| b_decay_time | output | 4 | Winding B selected decay timing value |

## Verification
A corrupted shift register stays invisible until the next strobe. At that strobe it shows up as a wrong field in exactly one winding, so the bench reads back every field after each transfer. A wrong table entry shows only when a winding's decay selector points at it. For that reason the tests step the selector through all four entries, both after reset and after a table write. A latch that reacts to a table write or to a bare shift burst shows up within three system clocks of the edge, as a change on the other winding's outputs.

// File: rtl/ms_cmd_pkg.sv
// Package: shared widths, word layout and torque decode for the
// serial micro-step command register.
package ms_cmd_pkg;

    localparam int WORD_W   = 16;
    localparam int LVL_W    = 4;
    localparam int TRQ_W    = 2;
    localparam int DEC_W    = 2;
    localparam int PCT_W    = 7;

    // Command word bit positions
    localparam int SEL_BIT  = 15;
    localparam int PH_BIT   = 8;
    localparam int LVL_LSB  = 4;
    localparam int TRQ_LSB  = 2;
    localparam int DEC_LSB  = 0;

    typedef struct packed {
        logic             phase;
        logic [LVL_W-1:0] level;
        logic [TRQ_W-1:0] torque;
        logic [DEC_W-1:0] decay;
    } wind_cmd_t;

    // Unpack one command word into winding fields
    function automatic wind_cmd_t unpack_cmd(input logic [WORD_W-1:0] w);
        wind_cmd_t c;
        c.phase  = w[PH_BIT];
        c.level  = w[LVL_LSB +: LVL_W];
        c.torque = w[TRQ_LSB +: TRQ_W];
        c.decay  = w[DEC_LSB +: DEC_W];
        return c;
    endfunction

    // Torque select to percent of full scale
    function automatic logic [PCT_W-1:0] torque_pct(input logic [TRQ_W-1:0] t);
        logic [PCT_W-1:0] p;
        case (t)
            2'd0:    p = 7'd100;
            2'd1:    p = 7'd85;
            2'd2:    p = 7'd70;
            default: p = 7'd50;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/ms_edge_sync.sv
// Module: ms_edge_sync
// Synchronises an asynchronous level into clk with STAGES flops and
// flags its rising edge for one cycle.
// Assumes: the input level is held for at least STAGES+1 clk cycles.
module ms_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise
);

    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift the input through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
    end

    // Remember the last synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~prev;

endmodule

// File: rtl/ms_shift_in.sv
// Module: ms_shift_in
// Serial-in parallel-out register, MSB first: each enabled cycle the
// word moves up one place and the new bit enters at bit 0.
// Assumes: shift_en is a single-cycle pulse per serial bit.
module ms_shift_in #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] word
);

    // Shift one bit on each enable, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n)        word <= '0;
        else if (shift_en) word <= {word[W-2:0], bit_in};
    end

    // R1: an enabled cycle moves the old low bits up by one
    p_shift_moves_r1: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> word[W-1:1] == $past(word[W-2:0]));

    // R8: the word holds while no shift is requested
    p_shift_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(word));

endmodule

// File: rtl/ms_decay_table.sv
// Module: ms_decay_table
// Writable mixed-decay timing table with a number of read ports.
// A write takes the whole word: entry k comes from bits k*ENT_W upward.
// Reset reloads DEFAULTS.
// Assumes: ENTRIES*ENT_W equals the serial word width.
module ms_decay_table #(
    parameter int                     ENTRIES  = 4,
    parameter int                     ENT_W    = 4,
    parameter int                     NRD      = 2,
    parameter logic [ENTRIES*ENT_W-1:0] DEFAULTS = 16'hA631
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [ENTRIES*ENT_W-1:0]           wr_word,
    input  logic [NRD-1:0][$clog2(ENTRIES)-1:0] rd_sel,
    output logic [NRD-1:0][ENT_W-1:0]          rd_val
);

    logic [ENTRIES-1:0][ENT_W-1:0] tbl;

    // Load defaults on reset, whole-word overwrite on write
    always_ff @(posedge clk) begin
        if (!rst_n)     tbl <= DEFAULTS;
        else if (wr_en) tbl <= wr_word;
    end

    // One combinational read port per consumer
    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rd_val[r] = tbl[rd_sel[r]];
    end

    // R7: reset leaves the default table behind
    p_tbl_default_r7: assert property (@(posedge clk)
        !rst_n |=> tbl == DEFAULTS);

    // R5: the table only changes on a write
    p_tbl_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(tbl));

endmodule

// File: rtl/ms_wind_latch.sv
// Module: ms_wind_latch
// Parallel command latch for one winding; loads on a one-cycle pulse.
// Assumes: load is already qualified by strobe, setup and winding select.
module ms_wind_latch
    import ms_cmd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  wind_cmd_t cmd_d,
    output wind_cmd_t cmd_q
);

    // Capture the decoded command when told to, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n)    cmd_q <= '0;
        else if (load) cmd_q <= cmd_d;
    end

    // R7: reset clears every field
    p_latch_clear_r7: assert property (@(posedge clk)
        !rst_n |=> cmd_q == '0);

    // R2: fields hold while not loaded
    p_latch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cmd_q));

endmodule

// File: rtl/ms_cmd_register.sv
// Module: ms_cmd_register (top)
// Serial micro-step command register for two windings. It synchronises
// the serial link, shifts 16 bits MSB first, and on a strobe edge routes
// the word either to the winding latch picked by bit 15 (setup low) or to
// the decay timing table (setup high).
// Assumes: link signals change slowly relative to clk (each level held for
// at least three clk cycles) and setup is settled before the strobe rises.
module ms_cmd_register
    import ms_cmd_pkg::*;
#(
    parameter int                 SYNC_STAGES = 2,
    parameter logic [WORD_W-1:0]  TBL_DEFAULT = 16'hA631
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_data,
    input  logic             ser_clk,
    input  logic             ser_strobe,
    input  logic             setup,
    output logic             a_phase,
    output logic [LVL_W-1:0] a_level,
    output logic [TRQ_W-1:0] a_torque,
    output logic [PCT_W-1:0] a_torque_pct,
    output logic [DEC_W-1:0] a_decay_sel,
    output logic [LVL_W-1:0] a_decay_time,
    output logic             b_phase,
    output logic [LVL_W-1:0] b_level,
    output logic [TRQ_W-1:0] b_torque,
    output logic [PCT_W-1:0] b_torque_pct,
    output logic [DEC_W-1:0] b_decay_sel,
    output logic [LVL_W-1:0] b_decay_time
);

    localparam int NSIG    = 4;
    localparam int NWIND   = 2;
    localparam int TBL_ENT = 1 << DEC_W;
    localparam int TBL_W   = WORD_W / TBL_ENT;

    // Synchroniser input order: data, shift clock, strobe, setup
    logic [NSIG-1:0] raw_in, sync_lvl, sync_rise;
    assign raw_in = {setup, ser_strobe, ser_clk, ser_data};

    for (genvar s = 0; s < NSIG; s++) begin : g_sync
        ms_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw_in[s]),
            .level (sync_lvl[s]),
            .rise  (sync_rise[s])
        );
    end

    logic data_s, shclk_rise, strb_rise, setup_s;
    assign data_s     = sync_lvl[0];
    assign shclk_rise = sync_rise[1];
    assign strb_rise  = sync_rise[2];
    assign setup_s    = sync_lvl[3];

    logic [WORD_W-1:0] shword;

    ms_shift_in #(.W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shclk_rise),
        .bit_in   (data_s),
        .word     (shword)
    );

    // Transfer routing
    logic       tbl_wr;
    logic [NWIND-1:0] wind_load;
    wind_cmd_t  cmd_new;
    wind_cmd_t  cmd_cur [NWIND];

    assign tbl_wr  = strb_rise & setup_s;
    assign cmd_new = unpack_cmd(shword);

    for (genvar w = 0; w < NWIND; w++) begin : g_wind
        assign wind_load[w] = strb_rise & ~setup_s & (shword[SEL_BIT] == w[0]);
        ms_wind_latch u_latch (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (wind_load[w]),
            .cmd_d (cmd_new),
            .cmd_q (cmd_cur[w])
        );
    end

    logic [NWIND-1:0][DEC_W-1:0] rd_sel;
    logic [NWIND-1:0][TBL_W-1:0] rd_val;
    assign rd_sel[0] = cmd_cur[0].decay;
    assign rd_sel[1] = cmd_cur[1].decay;

    ms_decay_table #(
        .ENTRIES  (TBL_ENT),
        .ENT_W    (TBL_W),
        .NRD      (NWIND),
        .DEFAULTS (TBL_DEFAULT)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_wr),
        .wr_word (shword),
        .rd_sel  (rd_sel),
        .rd_val  (rd_val)
    );

    // Output field mapping
    assign a_phase      = cmd_cur[0].phase;
    assign a_level      = cmd_cur[0].level;
    assign a_torque     = cmd_cur[0].torque;
    assign a_torque_pct = torque_pct(cmd_cur[0].torque);
    assign a_decay_sel  = cmd_cur[0].decay;
    assign a_decay_time = rd_val[0];
    assign b_phase      = cmd_cur[1].phase;
    assign b_level      = cmd_cur[1].level;
    assign b_torque     = cmd_cur[1].torque;
    assign b_torque_pct = torque_pct(cmd_cur[1].torque);
    assign b_decay_sel  = cmd_cur[1].decay;
    assign b_decay_time = rd_val[1];

    // R2: never both windings loaded by one strobe
    p_one_winding_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wind_load) <= 1);

    // R5: a table write leaves both winding outputs unchanged
    p_setup_keeps_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_wr |=> $stable({a_phase, a_level, a_torque, a_decay_sel,
                            b_phase, b_level, b_torque, b_decay_sel}));

    // R8: without a strobe edge no command output moves
    p_no_strobe_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !strb_rise |=> $stable({a_phase, a_level, a_torque, a_decay_sel, a_decay_time,
                                b_phase, b_level, b_torque, b_decay_sel, b_decay_time}));

endmodule

// File: tb/tb_ms_cmd_register.sv
`timescale 1ns/1ps
module tb_ms_cmd_register;

    logic       clk = 1'b0;
    logic       rst_n, ser_data, ser_clk, ser_strobe, setup;
    logic       a_phase, b_phase;
    logic [3:0] a_level, b_level, a_decay_time, b_decay_time;
    logic [1:0] a_torque, b_torque, a_decay_sel, b_decay_sel;
    logic [6:0] a_torque_pct, b_torque_pct;

    int checks = 0;
    int errors = 0;
    logic [3:0] tbl_m [4];

    always #2.5 clk = ~clk;

    ms_cmd_register dut (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
        .ser_strobe(ser_strobe), .setup(setup),
        .a_phase(a_phase), .a_level(a_level), .a_torque(a_torque),
        .a_torque_pct(a_torque_pct), .a_decay_sel(a_decay_sel), .a_decay_time(a_decay_time),
        .b_phase(b_phase), .b_level(b_level), .b_torque(b_torque),
        .b_torque_pct(b_torque_pct), .b_decay_sel(b_decay_sel), .b_decay_time(b_decay_time)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int pct_of(input logic [1:0] t);
        case (t)
            2'd0: return 100;
            2'd1: return 85;
            2'd2: return 70;
            default: return 50;
        endcase
    endfunction

    task automatic shift_bits(input logic [31:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = bits[i];
            wait_n(4);
            ser_clk = 1'b1;
            wait_n(4);
            ser_clk = 1'b0;
        end
    endtask

    task automatic strobe(input logic st);
        setup = st;
        wait_n(4);
        ser_strobe = 1'b1;
        wait_n(4);
        ser_strobe = 1'b0;
        wait_n(4);
        setup = 1'b0;
        wait_n(4);
    endtask

    task automatic send(input logic [15:0] w, input logic st);
        shift_bits({16'h0, w}, 16);
        strobe(st);
        if (st) for (int k = 0; k < 4; k++) tbl_m[k] = w[4*k +: 4];
    endtask

    task automatic chk_a(input string req, input logic [15:0] w);
        chk({req, " a_phase"},  a_phase,  w[8]);
        chk({req, " a_level"},  a_level,  w[7:4]);
        chk({req, " a_torque"}, a_torque, w[3:2]);
        chk({req, " a_pct"},    a_torque_pct, pct_of(w[3:2]));
        chk({req, " a_dsel"},   a_decay_sel, w[1:0]);
        chk({req, " a_dtime"},  a_decay_time, tbl_m[w[1:0]]);
    endtask

    task automatic chk_b(input string req, input logic [15:0] w);
        chk({req, " b_phase"},  b_phase,  w[8]);
        chk({req, " b_level"},  b_level,  w[7:4]);
        chk({req, " b_torque"}, b_torque, w[3:2]);
        chk({req, " b_pct"},    b_torque_pct, pct_of(w[3:2]));
        chk({req, " b_dsel"},   b_decay_sel, w[1:0]);
        chk({req, " b_dtime"},  b_decay_time, tbl_m[w[1:0]]);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wait_n(4);
        rst_n = 1'b1;
        tbl_m[0] = 4'd1; tbl_m[1] = 4'd3; tbl_m[2] = 4'd6; tbl_m[3] = 4'd10;
        wait_n(2);
    endtask

    // R7: reset state of both windings and default table
    task automatic t_reset();
        chk_a("R7", 16'h0000);
        chk_b("R7", 16'h0000);
    endtask

    // R2 R3 R6: load A then B with distinct fields, other winding untouched
    task automatic t_load();
        logic [15:0] wa, wb;
        wa = 16'h7E00 | 16'h0100 | 16'h00B0 | 16'h0006; // ignored bits set, R3
        wb = 16'h8000 | 16'h0050 | 16'h0003;
        send(wa, 1'b0);
        chk_a("R3", wa);
        chk_b("R2", 16'h0000);
        send(wb, 1'b0);
        chk_b("R2", wb);
        chk_a("R2", wa);
    endtask

    // R4 R6: step torque and decay selector through every code on A
    task automatic t_torque_decay();
        for (int k = 0; k < 4; k++) begin
            logic [15:0] w;
            w = 16'h0000 | 16'(k << 2) | 16'(3 - k) | 16'h00F0;
            send(w, 1'b0);
            chk("R4 pct", a_torque_pct, pct_of(2'(k)));
            chk("R6 dtime", a_decay_time, tbl_m[3 - k]);
        end
    endtask

    // R5 R6: table write keeps latches, changes decay outputs
    task automatic t_table();
        logic [15:0] wa, wb;
        wa = 16'h0192;   // A: phase 1, level 9, torque 0, decay 2
        wb = 16'h80E7;   // B: level 14, torque 1, decay 3
        send(wa, 1'b0);
        send(wb, 1'b0);
        send(16'h5C2F, 1'b1);
        chk_a("R5", wa);
        chk_b("R5", wb);
        chk("R6 a table", a_decay_time, 4'hC);
        chk("R6 b table", b_decay_time, 4'h5);
    endtask

    // R1 R8: extra leading bits dropped; shifting alone changes nothing
    task automatic t_shift();
        logic [15:0] before_a;
        before_a = {7'h00, a_phase, a_level, a_torque, a_decay_sel};
        shift_bits(32'h000A_5A5A, 20);
        wait_n(4);
        chk_a("R8", before_a);
        strobe(1'b0);
        chk_a("R1", 16'h5A5A);
    endtask

    initial begin
        rst_n = 1'b0; ser_data = 1'b0; ser_clk = 1'b0; ser_strobe = 1'b0; setup = 1'b0;
        do_reset();
        t_reset();
        t_load();
        t_torque_decay();
        t_table();
        t_shift();
        do_reset();
        t_reset();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule